// File: doc/BRIEF.md
# Packet Extend/Shrink Descriptor Adjuster

This block rewrites transfer descriptors so that each packet grows or loses a configured number of items at its head, its tail, or both. A descriptor carries a packet length in items, a read address into the input buffer and a write address into the output buffer. The adjuster is split into two stages that sit on either side of an external scheduler. The front stage changes the length and read address before scheduling. The back stage corrects the length and write address after scheduling.

Shrinking is applied once, in the front stage: the length is cut, and a head shrink also moves the read address past the dropped items. Extension works differently. The front stage adds the extra items so that the scheduler reserves room for them. The back stage then removes the extra items from the transfer length again. It exports the scheduled, extended length as metadata for the output buffer, and moves the write address past the head extension.

Each adjustment has its own enable and a signed size. A negative size shrinks the packet. If a shrink would leave the length at zero or below, the length becomes one item and a sticky error flag is raised. Both stages are single registered pipeline stages with valid/ready handshakes.

Top module: `pkt_resize_adjust`

## Requirements
- R1: While reset is active and in the first cycle after it, pre_out_valid, post_out_valid and len_err are low.
- R2: The front stage outputs length = incoming length + FRONT_SIZE + BACK_SIZE, where each size counts only if its enable is set; negative sizes reduce the length.
- R3: In the front stage, a negative enabled FRONT_SIZE advances the read address by -FRONT_SIZE modulo 2^IBUF_AW. The write address passes through unchanged.
- R4: When the front-stage sum in R2 is below 1, the output length is 1 and len_err goes high. len_err stays high until reset.
- R5: The back stage outputs length = incoming length minus the sum of the positive enabled sizes. Shrinks are not compensated. A result below 1 gives 1 and sets len_err.
- R6: The back stage outputs post_out_meta_len equal to the incoming (scheduled) length.
- R7: In the back stage, a positive enabled FRONT_SIZE advances the write address by FRONT_SIZE modulo 2^OBUF_AW. The read address passes through unchanged.
- R8: An adjustment whose enable is clear has no effect on any output, whatever its size.
- R9: In each stage, a descriptor accepted on a clock edge (valid and ready both high) appears at the output after that edge. It is held stable while out_ready is low. in_ready equals (not out_valid) or out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_in_valid | input | 1 | Front stage descriptor valid |
| pre_in_ready | output | 1 | Front stage can accept |
| pre_in_len | input | LEN_W | Original packet length in items |
| pre_in_rd_addr | input | IBUF_AW | Input-buffer read address |
| pre_in_wr_addr | input | OBUF_AW | Output-buffer write address |
| pre_out_valid | output | 1 | Adjusted descriptor valid, toward scheduler |
| pre_out_ready | input | 1 | Scheduler accepts |
| pre_out_len | output | LEN_W | Adjusted length |
| pre_out_rd_addr | output | IBUF_AW | Adjusted read address |
| pre_out_wr_addr | output | OBUF_AW | Write address, unchanged |
| post_in_valid | input | 1 | Scheduled descriptor valid |
| post_in_ready | output | 1 | Back stage can accept |
| post_in_len | input | LEN_W | Scheduled (extended) length |
| post_in_rd_addr | input | IBUF_AW | Read address from scheduler |
| post_in_wr_addr | input | OBUF_AW | Write address from scheduler |
| post_out_valid | output | 1 | Corrected descriptor valid |
| post_out_ready | input | 1 | Downstream accepts |
| post_out_len | output | LEN_W | Corrected transfer length |
| post_out_rd_addr | output | IBUF_AW | Read address, unchanged |
| post_out_wr_addr | output | OBUF_AW | Corrected write address |
| post_out_meta_len | output | LEN_W | Extended length for the output buffer |
| len_err | output | 1 | Sticky length-clamp error |

## Verification
The bench drives two instances. One shrinks at both ends. The other extends at the head and has a disabled tail size of 7. It targets a shrink that lands exactly on one item and one that lands on zero: a design with an off-by-one clamp would pass zero through or flag a legal length. It checks read and write addresses next to the top of the address range, where a missing modulo would give out-of-range values. It also checks a back-stage length smaller than the extension, and long output stalls during which a stage that drops or overwrites its held descriptor would lose or corrupt packets. The disabled tail size would show up as a length seven items too long if the enable were ignored.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
    // Effective signed adjustment: zero when disabled.
    function automatic int eff_adj(input bit en, input int size);
        return en ? size : 0;
    endfunction

    function automatic int pos_part(input int v);
        return (v > 0) ? v : 0;
    endfunction

    function automatic int neg_mag(input int v);
        return (v < 0) ? -v : 0;
    endfunction
endpackage

// File: rtl/rsz_pipe_reg.sv
module rsz_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    assign in_ready  = !slot_q.valid || out_ready;
    assign out_valid = slot_q.valid;
    assign out_data  = slot_q.data;

    always_comb begin
        slot_d = slot_q;
        if (in_ready) begin
            slot_d.valid = in_valid;
            if (in_valid) slot_d.data = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end
endmodule

// File: rtl/rsz_pre_stage.sv
module rsz_pre_stage #(
    parameter int LEN_W   = 12,
    parameter int RD_AW   = 12,
    parameter int WR_AW   = 12,
    parameter int LEN_ADJ = 0,
    parameter int RD_SKIP = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LEN_W-1:0] in_len,
    input  logic [RD_AW-1:0] in_rd,
    input  logic [WR_AW-1:0] in_wr,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LEN_W-1:0] out_len,
    output logic [RD_AW-1:0] out_rd,
    output logic [WR_AW-1:0] out_wr,
    output logic             clamp_o
);
    localparam int DW = LEN_W + RD_AW + WR_AW;

    int               total;
    logic [LEN_W-1:0] len_n;
    logic [RD_AW-1:0] rd_n;
    logic [DW-1:0]    pack_in, pack_out;

    always_comb begin
        total   = int'(in_len) + LEN_ADJ;
        len_n   = (total < 1) ? LEN_W'(1) : LEN_W'(total);
        rd_n    = in_rd + RD_AW'(RD_SKIP);
        clamp_o = in_valid && in_ready && (total < 1);
        pack_in = {len_n, rd_n, in_wr};
    end

    rsz_pipe_reg #(.W(DW)) i_reg (
        .clk, .rst_n,
        .in_valid, .in_ready, .in_data(pack_in),
        .out_valid, .out_ready, .out_data(pack_out)
    );

    assign {out_len, out_rd, out_wr} = pack_out;
endmodule

// File: rtl/rsz_post_stage.sv
module rsz_post_stage #(
    parameter int LEN_W   = 12,
    parameter int RD_AW   = 12,
    parameter int WR_AW   = 12,
    parameter int LEN_SUB = 0,
    parameter int WR_SKIP = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LEN_W-1:0] in_len,
    input  logic [RD_AW-1:0] in_rd,
    input  logic [WR_AW-1:0] in_wr,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LEN_W-1:0] out_len,
    output logic [RD_AW-1:0] out_rd,
    output logic [WR_AW-1:0] out_wr,
    output logic [LEN_W-1:0] out_meta,
    output logic             clamp_o
);
    localparam int DW = 2 * LEN_W + RD_AW + WR_AW;

    int               rest;
    logic [LEN_W-1:0] len_n;
    logic [WR_AW-1:0] wr_n;
    logic [DW-1:0]    pack_in, pack_out;

    always_comb begin
        rest    = int'(in_len) - LEN_SUB;
        len_n   = (rest < 1) ? LEN_W'(1) : LEN_W'(rest);
        wr_n    = in_wr + WR_AW'(WR_SKIP);
        clamp_o = in_valid && in_ready && (rest < 1);
        pack_in = {len_n, in_len, in_rd, wr_n};
    end

    rsz_pipe_reg #(.W(DW)) i_reg (
        .clk, .rst_n,
        .in_valid, .in_ready, .in_data(pack_in),
        .out_valid, .out_ready, .out_data(pack_out)
    );

    assign {out_len, out_meta, out_rd, out_wr} = pack_out;
endmodule

// File: rtl/pkt_resize_adjust.sv
module pkt_resize_adjust #(
    parameter bit FRONT_EN   = 1'b1,
    parameter int FRONT_SIZE = -4,
    parameter bit BACK_EN    = 1'b1,
    parameter int BACK_SIZE  = -5,
    parameter int MAX_LEN    = 1024,
    parameter int IBUF_AW    = 12,
    parameter int OBUF_AW    = 12,
    parameter int LEN_W      = $clog2(MAX_LEN + 1) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pre_in_valid,
    output logic               pre_in_ready,
    input  logic [LEN_W-1:0]   pre_in_len,
    input  logic [IBUF_AW-1:0] pre_in_rd_addr,
    input  logic [OBUF_AW-1:0] pre_in_wr_addr,
    output logic               pre_out_valid,
    input  logic               pre_out_ready,
    output logic [LEN_W-1:0]   pre_out_len,
    output logic [IBUF_AW-1:0] pre_out_rd_addr,
    output logic [OBUF_AW-1:0] pre_out_wr_addr,
    input  logic               post_in_valid,
    output logic               post_in_ready,
    input  logic [LEN_W-1:0]   post_in_len,
    input  logic [IBUF_AW-1:0] post_in_rd_addr,
    input  logic [OBUF_AW-1:0] post_in_wr_addr,
    output logic               post_out_valid,
    input  logic               post_out_ready,
    output logic [LEN_W-1:0]   post_out_len,
    output logic [IBUF_AW-1:0] post_out_rd_addr,
    output logic [OBUF_AW-1:0] post_out_wr_addr,
    output logic [LEN_W-1:0]   post_out_meta_len,
    output logic               len_err
);
    import rsz_pkg::*;

    localparam int F_ADJ   = eff_adj(FRONT_EN, FRONT_SIZE);
    localparam int B_ADJ   = eff_adj(BACK_EN, BACK_SIZE);
    localparam int PRE_ADJ = F_ADJ + B_ADJ;
    localparam int RD_SKIP = neg_mag(F_ADJ);
    localparam int EXT_SUM = pos_part(F_ADJ) + pos_part(B_ADJ);
    localparam int WR_SKIP = pos_part(F_ADJ);

    logic pre_clamp, post_clamp;
    logic err_d, err_q;

    rsz_pre_stage #(
        .LEN_W(LEN_W), .RD_AW(IBUF_AW), .WR_AW(OBUF_AW),
        .LEN_ADJ(PRE_ADJ), .RD_SKIP(RD_SKIP)
    ) i_pre (
        .clk, .rst_n,
        .in_valid(pre_in_valid), .in_ready(pre_in_ready),
        .in_len(pre_in_len), .in_rd(pre_in_rd_addr), .in_wr(pre_in_wr_addr),
        .out_valid(pre_out_valid), .out_ready(pre_out_ready),
        .out_len(pre_out_len), .out_rd(pre_out_rd_addr), .out_wr(pre_out_wr_addr),
        .clamp_o(pre_clamp)
    );

    rsz_post_stage #(
        .LEN_W(LEN_W), .RD_AW(IBUF_AW), .WR_AW(OBUF_AW),
        .LEN_SUB(EXT_SUM), .WR_SKIP(WR_SKIP)
    ) i_post (
        .clk, .rst_n,
        .in_valid(post_in_valid), .in_ready(post_in_ready),
        .in_len(post_in_len), .in_rd(post_in_rd_addr), .in_wr(post_in_wr_addr),
        .out_valid(post_out_valid), .out_ready(post_out_ready),
        .out_len(post_out_len), .out_rd(post_out_rd_addr), .out_wr(post_out_wr_addr),
        .out_meta(post_out_meta_len), .clamp_o(post_clamp)
    );

    always_comb begin
        err_d = err_q | pre_clamp | post_clamp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign len_err = err_q;
endmodule

// File: rtl/rsz_checker.sv
module rsz_checker #(
    parameter int LEN_W   = 12,
    parameter int IBUF_AW = 12,
    parameter int OBUF_AW = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pre_in_ready,
    input logic               pre_out_valid,
    input logic               pre_out_ready,
    input logic [LEN_W-1:0]   pre_out_len,
    input logic [IBUF_AW-1:0] pre_out_rd_addr,
    input logic [OBUF_AW-1:0] pre_out_wr_addr,
    input logic               post_in_ready,
    input logic               post_out_valid,
    input logic               post_out_ready,
    input logic [LEN_W-1:0]   post_out_len,
    input logic [LEN_W-1:0]   post_out_meta_len,
    input logic [OBUF_AW-1:0] post_out_wr_addr,
    input logic               len_err
);
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pre_out_valid && !pre_out_ready |=> pre_out_valid && $stable(pre_out_len)
        && $stable(pre_out_rd_addr) && $stable(pre_out_wr_addr)); // R9
    AST_POST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        post_out_valid && !post_out_ready |=> post_out_valid && $stable(post_out_len)
        && $stable(post_out_meta_len) && $stable(post_out_wr_addr)); // R9
    AST_PRE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_out_valid |-> pre_in_ready); // R9
    AST_POST_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !post_out_valid |-> post_in_ready); // R9
    AST_PRE_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        pre_out_valid |-> pre_out_len >= LEN_W'(1)); // R4
    AST_POST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        post_out_valid |-> post_out_len >= LEN_W'(1)); // R5
    AST_META_GE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        post_out_valid |-> post_out_meta_len >= post_out_len); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err); // R4
endmodule

bind pkt_resize_adjust rsz_checker #(
    .LEN_W(LEN_W), .IBUF_AW(IBUF_AW), .OBUF_AW(OBUF_AW)
) i_chk (
    .clk(clk), .rst_n(rst_n),
    .pre_in_ready(pre_in_ready), .pre_out_valid(pre_out_valid),
    .pre_out_ready(pre_out_ready), .pre_out_len(pre_out_len),
    .pre_out_rd_addr(pre_out_rd_addr), .pre_out_wr_addr(pre_out_wr_addr),
    .post_in_ready(post_in_ready), .post_out_valid(post_out_valid),
    .post_out_ready(post_out_ready), .post_out_len(post_out_len),
    .post_out_meta_len(post_out_meta_len), .post_out_wr_addr(post_out_wr_addr),
    .len_err(len_err)
);

// File: tb/test_pkt_resize_adjust.sv
module test_pkt_resize_adjust;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int LW = 12;
    localparam int AMOD = 1 << AW;
    // Instance A: shrink front 4, back 5. Instance B: extend front 3, back disabled (size 7).
    localparam int FA = -4, BA = -5;
    localparam int FB = 3,  BB = 0;

    typedef struct { int len; int rd; int wr; int meta; } d_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pv = 0, pr = 0, qv = 0, qr = 0;
    logic [LW-1:0] plen = '0, qlen = '0;
    logic [AW-1:0] prd = '0, pwr = '0, qrd = '0, qwr = '0;

    logic a_pir, a_pov, a_qir, a_qov, a_err;
    logic [LW-1:0] a_pol, a_qol, a_qom;
    logic [AW-1:0] a_por, a_pow, a_qor, a_qow;
    logic b_pir, b_pov, b_qir, b_qov, b_err;
    logic [LW-1:0] b_pol, b_qol, b_qom;
    logic [AW-1:0] b_por, b_pow, b_qor, b_qow;

    int nvec = 0, nbad = 0;
    bit done = 0;
    d_t qpa[$], qpb[$], qsa[$], qsb[$];
    bit ea = 0, eb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_resize_adjust i_pkt_resize_adjust (
        .clk, .rst_n,
        .pre_in_valid(pv), .pre_in_ready(a_pir), .pre_in_len(plen),
        .pre_in_rd_addr(prd), .pre_in_wr_addr(pwr),
        .pre_out_valid(a_pov), .pre_out_ready(pr), .pre_out_len(a_pol),
        .pre_out_rd_addr(a_por), .pre_out_wr_addr(a_pow),
        .post_in_valid(qv), .post_in_ready(a_qir), .post_in_len(qlen),
        .post_in_rd_addr(qrd), .post_in_wr_addr(qwr),
        .post_out_valid(a_qov), .post_out_ready(qr), .post_out_len(a_qol),
        .post_out_rd_addr(a_qor), .post_out_wr_addr(a_qow),
        .post_out_meta_len(a_qom), .len_err(a_err)
    );

    pkt_resize_adjust #(.FRONT_EN(1'b1), .FRONT_SIZE(3), .BACK_EN(1'b0), .BACK_SIZE(7))
    i_pkt_resize_adjust_ext (
        .clk, .rst_n,
        .pre_in_valid(pv), .pre_in_ready(b_pir), .pre_in_len(plen),
        .pre_in_rd_addr(prd), .pre_in_wr_addr(pwr),
        .pre_out_valid(b_pov), .pre_out_ready(pr), .pre_out_len(b_pol),
        .pre_out_rd_addr(b_por), .pre_out_wr_addr(b_pow),
        .post_in_valid(qv), .post_in_ready(b_qir), .post_in_len(qlen),
        .post_in_rd_addr(qrd), .post_in_wr_addr(qwr),
        .post_out_valid(b_qov), .post_out_ready(qr), .post_out_len(b_qol),
        .post_out_rd_addr(b_qor), .post_out_wr_addr(b_qow),
        .post_out_meta_len(b_qom), .len_err(b_err)
    );

    function automatic d_t pre_m(int f, int b, int len, int rd, int wr, output bit clamp);
        d_t r;
        int t = len + f + b;
        clamp = (t < 1);
        r.len = clamp ? 1 : t;
        r.rd = (rd + ((f < 0) ? -f : 0)) % AMOD;
        r.wr = wr;
        r.meta = 0;
        return r;
    endfunction

    function automatic d_t post_m(int f, int b, int len, int rd, int wr, output bit clamp);
        d_t r;
        int t = len - ((f > 0) ? f : 0) - ((b > 0) ? b : 0);
        clamp = (t < 1);
        r.len = clamp ? 1 : t;
        r.rd = rd;
        r.wr = (wr + ((f > 0) ? f : 0)) % AMOD;
        r.meta = len;
        return r;
    endfunction

    // Reference model: one-deep queue per stage and instance, updated on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            qpa.delete(); qpb.delete(); qsa.delete(); qsb.delete();
            ea = 0; eb = 0;
        end else begin
            bit c;
            bit rpa, rpb, rsa, rsb;
            rpa = (qpa.size() == 0) || pr;
            rpb = (qpb.size() == 0) || pr;
            rsa = (qsa.size() == 0) || qr;
            rsb = (qsb.size() == 0) || qr;
            if (qpa.size() > 0 && pr) void'(qpa.pop_front());
            if (qpb.size() > 0 && pr) void'(qpb.pop_front());
            if (qsa.size() > 0 && qr) void'(qsa.pop_front());
            if (qsb.size() > 0 && qr) void'(qsb.pop_front());
            if (pv && rpa) begin qpa.push_back(pre_m(FA, BA, int'(plen), int'(prd), int'(pwr), c)); ea |= c; end
            if (pv && rpb) begin qpb.push_back(pre_m(FB, BB, int'(plen), int'(prd), int'(pwr), c)); eb |= c; end
            if (qv && rsa) begin qsa.push_back(post_m(FA, BA, int'(qlen), int'(qrd), int'(qwr), c)); ea |= c; end
            if (qv && rsb) begin qsb.push_back(post_m(FB, BB, int'(qlen), int'(qrd), int'(qwr), c)); eb |= c; end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cmp_stage(string who, string lentag, bit post, logic av, logic ardy,
                             int al, int ar, int aw, int am, int qn, d_t h, logic ordy);
        chk("R9", {who, " valid"}, int'(av), (qn > 0) ? 1 : 0);
        chk("R9", {who, " in_ready"}, int'(ardy), (qn == 0 || ordy) ? 1 : 0);
        if (qn > 0) begin
            chk(lentag, {who, " len"}, al, h.len);
            chk(post ? "R7" : "R3", {who, " rd"}, ar, h.rd);
            chk(post ? "R7" : "R3", {who, " wr"}, aw, h.wr);
            if (post) chk("R6", {who, " meta"}, am, h.meta);
        end
    endtask

    function automatic d_t head(d_t q[$]);
        d_t z = '{default: 0};
        return (q.size() > 0) ? q[0] : z;
    endfunction

    task automatic cmp_all();
        cmp_stage("A pre", "R2", 0, a_pov, a_pir, int'(a_pol), int'(a_por), int'(a_pow), 0,
                  qpa.size(), head(qpa), pr);
        cmp_stage("B pre", "R8", 0, b_pov, b_pir, int'(b_pol), int'(b_por), int'(b_pow), 0,
                  qpb.size(), head(qpb), pr);
        cmp_stage("A post", "R5", 1, a_qov, a_qir, int'(a_qol), int'(a_qor), int'(a_qow), int'(a_qom),
                  qsa.size(), head(qsa), qr);
        cmp_stage("B post", "R5", 1, b_qov, b_qir, int'(b_qol), int'(b_qor), int'(b_qow), int'(b_qom),
                  qsb.size(), head(qsb), qr);
        chk("R4", "A len_err", int'(a_err), int'(ea));
        chk("R4", "B len_err", int'(b_err), int'(eb));
    endtask

    task automatic step(logic v1, int l1, int r1, int w1, logic o1,
                        logic v2, int l2, int r2, int w2, logic o2);
        @(negedge clk);
        cmp_all();
        pv = v1; plen = LW'(l1); prd = AW'(r1); pwr = AW'(w1); pr = o1;
        qv = v2; qlen = LW'(l2); qrd = AW'(r2); qwr = AW'(w2); qr = o2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        chk("R1", "A pre valid in reset", int'(a_pov), 0);
        chk("R1", "A post valid in reset", int'(a_qov), 0);
        chk("R1", "A err in reset", int'(a_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "A pre valid after reset", int'(a_pov), 0);
        chk("R1", "B post valid after reset", int'(b_qov), 0);
        chk("R1", "B err after reset", int'(b_err), 0);
        // R2 exact-one shrink; R7 write wrap (B: 4095+3 -> 2)
        step(1, 10, 0, 5, 1,        1, 20, 17, 4095, 1);
        // R3 read wrap (A: 4094+4 -> 2); R4 clamp (A: 9-9=0); R5 clamp (B: 2-3)
        step(1, 9, 4094, 0, 1,      1, 2, 100, 7, 1);
        // R9 stall: hold ready low with new offers pending
        step(1, 1024, 4092, 4095, 0, 1, 1027, 4095, 4093, 0);
        step(1, 5, 3, 3, 0,         1, 9, 1, 1, 0);
        step(1, 5, 3, 3, 0,         1, 9, 1, 1, 0);
        step(1, 5, 3, 3, 1,         1, 9, 1, 1, 1);
        step(0, 0, 0, 0, 1,         0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1,         0, 0, 0, 0, 1);
        // Random traffic with random back-pressure
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom_range(0, 3) != 0), $urandom_range(1, 1024),
                 $urandom_range(0, AMOD - 1), $urandom_range(0, AMOD - 1),
                 1'($urandom_range(0, 2) != 0),
                 1'($urandom_range(0, 3) != 0), $urandom_range(1, 1030),
                 $urandom_range(0, AMOD - 1), $urandom_range(0, AMOD - 1),
                 1'($urandom_range(0, 2) != 0));
        end
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule